// File: doc/BRIEF.md
# Queued Chunked DMA Command Engine

This block is a small memory-to-memory mover driven from a register window. Software loads a source address, a destination address and two word counts, and the write of the destination count turns those four values into one command held in a short command queue. The engine takes commands from the head of the queue in arrival order. It runs each one as a series of bursts of at most `MAX_BURST_BYTES` bytes, moving one 32-bit word per cycle over a word-wide memory port.

Read data is copied to the destination only while the loopback control bit is set. Otherwise the engine only reads the source. When a command can make no further progress, the engine retires it, pops it from the queue and raises completion flags in an interrupt status register. That register has write-one-to-clear bits, and its masked OR drives a single interrupt line.

Top module: `qdma_engine`

## Requirements
- R1: Register byte offsets are 0x18 source address, 0x1C destination address, 0x20 source length, 0x24 destination length, 0x0C interrupt status, 0x10 interrupt mask, 0x14 queue status and 0x80 misc control. A write to offset 0x24 captures all four transfer registers, taking the destination length from that same write, and enqueues them as one command.
- R2: Captured source and destination addresses have bits 1:0 cleared. Every memory read and write address issued is word aligned.
- R3: Both length registers count 32-bit words, and only bits 26:0 are stored. A read returns the stored value with bits 31:27 zero. Byte length equals the word count times four.
- R4: A burst is a run of consecutive cycles with `mem_rd` high, one word per cycle, and bursts are separated by at least one cycle with `mem_rd` low. A burst moves the smaller of `MAX_BURST_BYTES` and the remaining source length. In loopback mode it is also capped by the remaining destination length.
- R5: Within a command, read addresses ascend by 4 from the aligned source address across all bursts.
- R6: When bit 4 of the misc control register (0x80) is 1, each word read is written in the same cycle to the destination, at addresses ascending by 4 from the aligned destination address. When the bit is 0, `mem_wr` stays low.
- R7: A command retires when its next burst size is zero. This covers a zero-length command, a source fully consumed in non-loopback mode whatever its destination length, and a loopback command whose destination length runs out first. Retiring sets interrupt status bits 13 and 12 and pops the command.
- R8: The queue holds `QUEUE_DEPTH` commands, including the one executing, and runs them in FIFO order. An enqueue while full is dropped and sets interrupt status bit 14.
- R9: Queue status at 0x14 reports bit 31 = queue full and bit 30 = queue empty. All other bits read 0, and the reset value is 0x4000_0000.
- R10: `irq` is the OR over all bits of (interrupt status AND NOT mask). The mask at 0x10 resets to 0xFFFF_FFFF and is fully writable.
- R11: Interrupt status at 0x0C resets to 0x8802_0000. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. Hardware sets bits 12, 13 and 14 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_rd | output | 1 | Memory read strobe, one word this cycle |
| mem_raddr | output | 32 | Memory read byte address |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_waddr | output | 32 | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the engine with `MAX_BURST_BYTES` = 32 and `QUEUE_DEPTH` = 4. With an 8-word burst, commands of a few dozen words split into several bursts with a short final burst, so the burst cap and the address carry across bursts can be checked at low cycle cost. A 64-word head command keeps the queue occupied long enough to fill all four slots and provoke a dropped fifth push. Loopback, truncation by a short destination length and zero-length retirement are each run separately.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 27;
    localparam int BLEN_W = LEN_W + 2;
    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_INT_STS  = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_INT_MASK = 8'h10;
    localparam logic [REG_AW-1:0] OFS_STATUS   = 8'h14;
    localparam logic [REG_AW-1:0] OFS_SRC_ADDR = 8'h18;
    localparam logic [REG_AW-1:0] OFS_DST_ADDR = 8'h1C;
    localparam logic [REG_AW-1:0] OFS_SRC_LEN  = 8'h20;
    localparam logic [REG_AW-1:0] OFS_DST_LEN  = 8'h24;
    localparam logic [REG_AW-1:0] OFS_MISC     = 8'h80;

    localparam int BIT_PDONE  = 12;
    localparam int BIT_DONE   = 13;
    localparam int BIT_QOVF   = 14;
    localparam int BIT_QEMPTY = 30;
    localparam int BIT_QFULL  = 31;
    localparam int BIT_LPBK   = 4;

    localparam logic [31:0] INT_STS_RST = 32'h8802_0000;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [BLEN_W-1:0] slen;
        logic [BLEN_W-1:0] dlen;
    } dma_cmd_t;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_PLAN = 2'd1,
        MV_MOVE = 2'd2
    } mv_state_e;

    function automatic logic [BLEN_W-1:0] min_len(input logic [BLEN_W-1:0] a,
                                                  input logic [BLEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/qdma_cmd_fifo.sv
module qdma_cmd_fifo
    import qdma_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  dma_cmd_t push_cmd,
    input  logic     pop,
    output dma_cmd_t head,
    output logic     head_valid,
    output logic     full,
    output logic     empty,
    output logic     overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    dma_cmd_t           slots [DEPTH];
    logic [PTR_W-1:0]   rd_ptr, wr_ptr;
    logic [CNT_W-1:0]   count;
    logic               accept, take;

    assign full       = (count == CNT_W'(DEPTH));
    assign empty      = (count == '0);
    assign head_valid = !empty;
    assign head       = slots[rd_ptr];
    assign accept     = push && !full;
    assign overflow   = push && full;
    assign take       = pop && !empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (take)   rd_ptr <= bump(rd_ptr);
            case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slots[i] <= '0;
                end else if (accept && wr_ptr == PTR_W'(i)) begin
                    slots[i] <= push_cmd;
                end
            end
        end
    endgenerate

    // R8: a dropped push leaves the occupancy untouched
    a_r8_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> $stable(count));

    // R8: occupancy never passes the configured depth
    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/qdma_regs.sv
module qdma_regs
    import qdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              done_pulse,
    input  logic              ovf_pulse,
    input  logic              q_full,
    input  logic              q_empty,
    output logic              push,
    output dma_cmd_t          push_cmd,
    output logic              lpbk,
    output logic              irq
);
    logic [ADDR_W-1:0] src_addr_q, dst_addr_q;
    logic [LEN_W-1:0]  src_len_q, dst_len_q;
    logic [31:0]       int_sts_q, int_mask_q;
    logic [31:0]       int_sts_nxt;
    logic              lpbk_q;

    function automatic logic hit(input logic [REG_AW-1:0] ofs);
        return reg_wr && (reg_addr == ofs);
    endfunction

    assign push = hit(OFS_DST_LEN);
    assign lpbk = lpbk_q;

    always_comb begin
        push_cmd.src  = word_align(src_addr_q);
        push_cmd.dst  = word_align(dst_addr_q);
        push_cmd.slen = {src_len_q, 2'b00};
        push_cmd.dlen = {reg_wdata[LEN_W-1:0], 2'b00};
    end

    always_comb begin
        int_sts_nxt = int_sts_q;
        if (hit(OFS_INT_STS)) int_sts_nxt = int_sts_nxt & ~reg_wdata;
        if (done_pulse) begin
            int_sts_nxt[BIT_DONE]  = 1'b1;
            int_sts_nxt[BIT_PDONE] = 1'b1;
        end
        if (ovf_pulse) int_sts_nxt[BIT_QOVF] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_addr_q <= '0;
            dst_addr_q <= '0;
            src_len_q  <= '0;
            dst_len_q  <= '0;
            int_sts_q  <= INT_STS_RST;
            int_mask_q <= '1;
            lpbk_q     <= 1'b0;
        end else begin
            int_sts_q <= int_sts_nxt;
            if (hit(OFS_SRC_ADDR)) src_addr_q <= reg_wdata;
            if (hit(OFS_DST_ADDR)) dst_addr_q <= reg_wdata;
            if (hit(OFS_SRC_LEN))  src_len_q  <= reg_wdata[LEN_W-1:0];
            if (hit(OFS_DST_LEN))  dst_len_q  <= reg_wdata[LEN_W-1:0];
            if (hit(OFS_INT_MASK)) int_mask_q <= reg_wdata;
            if (hit(OFS_MISC))     lpbk_q     <= reg_wdata[BIT_LPBK];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_INT_STS:  reg_rdata = int_sts_q;
            OFS_INT_MASK: reg_rdata = int_mask_q;
            OFS_STATUS: begin
                reg_rdata[BIT_QFULL]  = q_full;
                reg_rdata[BIT_QEMPTY] = q_empty;
            end
            OFS_SRC_ADDR: reg_rdata = src_addr_q;
            OFS_DST_ADDR: reg_rdata = dst_addr_q;
            OFS_SRC_LEN:  reg_rdata = {{(32-LEN_W){1'b0}}, src_len_q};
            OFS_DST_LEN:  reg_rdata = {{(32-LEN_W){1'b0}}, dst_len_q};
            OFS_MISC:     reg_rdata[BIT_LPBK] = lpbk_q;
            default:      reg_rdata = '0;
        endcase
    end

    assign irq = |(int_sts_q & ~int_mask_q);

    // R11: bit 31 is never set by hardware, so a write of one clears it for good
    a_r11_w1c_top_bit: assert property (@(posedge clk) disable iff (rst)
        (hit(OFS_INT_STS) && reg_wdata[31]) |=> !int_sts_q[31]);

    // R10: a fully set mask silences the line
    a_r10_mask_silences: assert property (@(posedge clk) disable iff (rst)
        (int_mask_q == 32'hFFFF_FFFF) |-> !irq);

    // R7: a completion pulse leaves both done flags set
    a_r7_done_flags: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> (int_sts_q[BIT_DONE] && int_sts_q[BIT_PDONE]));

endmodule

// File: rtl/qdma_mover.sv
module qdma_mover
    import qdma_pkg::*;
#(
    parameter int MAX_BURST_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              head_valid,
    input  dma_cmd_t          head,
    input  logic              lpbk,
    output logic              pop,
    output logic              done_pulse,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [31:0]       mem_rdata,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [31:0]       mem_wdata
);
    localparam int MAX_WORDS = MAX_BURST_BYTES / 4;
    localparam int IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
    localparam int WL_W      = BLEN_W - 2;
    localparam logic [BLEN_W-1:0] CAP = BLEN_W'(MAX_BURST_BYTES);

    mv_state_e          state;
    logic [ADDR_W-1:0]  cur_src, cur_dst;
    logic [BLEN_W-1:0]  rem_src, rem_dst;
    logic [BLEN_W-1:0]  burst_bytes;
    logic               burst_lb;
    logic [IDX_W-1:0]   idx;
    logic [BLEN_W-1:0]  next_size;
    logic [WL_W-1:0]    burst_wds;
    logic               at_last;
    logic [ADDR_W-1:0]  offset;

    always_comb begin
        next_size = min_len(CAP, rem_src);
        if (lpbk) next_size = min_len(next_size, rem_dst);
    end

    assign burst_wds  = burst_bytes[BLEN_W-1:2];
    assign at_last    = (WL_W'(idx) == (burst_wds - WL_W'(1)));
    assign offset     = ADDR_W'(idx) << 2;

    assign pop        = (state == MV_PLAN) && (next_size == '0);
    assign done_pulse = pop;

    assign mem_rd     = (state == MV_MOVE);
    assign mem_raddr  = cur_src + offset;
    assign mem_wr     = (state == MV_MOVE) && burst_lb;
    assign mem_waddr  = cur_dst + offset;
    assign mem_wdata  = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= MV_IDLE;
            cur_src     <= '0;
            cur_dst     <= '0;
            rem_src     <= '0;
            rem_dst     <= '0;
            burst_bytes <= '0;
            burst_lb    <= 1'b0;
            idx         <= '0;
        end else begin
            case (state)
                MV_IDLE: begin
                    if (head_valid) begin
                        cur_src <= head.src;
                        cur_dst <= head.dst;
                        rem_src <= head.slen;
                        rem_dst <= head.dlen;
                        state   <= MV_PLAN;
                    end
                end
                MV_PLAN: begin
                    if (next_size == '0) begin
                        state <= MV_IDLE;
                    end else begin
                        burst_bytes <= next_size;
                        burst_lb    <= lpbk;
                        idx         <= '0;
                        state       <= MV_MOVE;
                    end
                end
                MV_MOVE: begin
                    if (at_last) begin
                        cur_src <= cur_src + ADDR_W'(burst_bytes);
                        rem_src <= rem_src - burst_bytes;
                        if (burst_lb) begin
                            cur_dst <= cur_dst + ADDR_W'(burst_bytes);
                            rem_dst <= rem_dst - burst_bytes;
                        end
                        state <= MV_PLAN;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= MV_IDLE;
            endcase
        end
    end

    // R4: every burst in flight is non-empty and within the cap
    a_r4_burst_cap: assert property (@(posedge clk) disable iff (rst)
        (state == MV_MOVE) |-> (burst_bytes != '0 && burst_bytes <= CAP));

    // R4: a burst ends with a cycle free of reads
    a_r4_burst_gap: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && at_last) |=> !mem_rd);

    // R5: read addresses step by one word inside a burst
    a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !at_last) |=> (mem_raddr == $past(mem_raddr) + 32'd4));

    // R2: issued addresses are word aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_raddr[1:0] == 2'b00 && mem_waddr[1:0] == 2'b00));

endmodule

// File: rtl/qdma_engine.sv
module qdma_engine
    import qdma_pkg::*;
#(
    parameter int QUEUE_DEPTH     = 4,
    parameter int MAX_BURST_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_rd,
    output logic [31:0] mem_raddr,
    input  logic [31:0] mem_rdata,
    output logic        mem_wr,
    output logic [31:0] mem_waddr,
    output logic [31:0] mem_wdata,
    output logic        irq
);
    dma_cmd_t push_cmd, head;
    logic     push, pop, head_valid, q_full, q_empty, q_ovf;
    logic     done_pulse, lpbk;

    qdma_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .done_pulse (done_pulse),
        .ovf_pulse  (q_ovf),
        .q_full     (q_full),
        .q_empty    (q_empty),
        .push       (push),
        .push_cmd   (push_cmd),
        .lpbk       (lpbk),
        .irq        (irq)
    );

    qdma_cmd_fifo #(.DEPTH(QUEUE_DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_cmd   (push_cmd),
        .pop        (pop),
        .head       (head),
        .head_valid (head_valid),
        .full       (q_full),
        .empty      (q_empty),
        .overflow   (q_ovf)
    );

    qdma_mover #(.MAX_BURST_BYTES(MAX_BURST_BYTES)) u_mover (
        .clk        (clk),
        .rst        (rst),
        .head_valid (head_valid),
        .head       (head),
        .lpbk       (lpbk),
        .pop        (pop),
        .done_pulse (done_pulse),
        .mem_rd     (mem_rd),
        .mem_raddr  (mem_raddr),
        .mem_rdata  (mem_rdata),
        .mem_wr     (mem_wr),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata)
    );

    // R6: a destination write only ever accompanies a read of the same word
    a_r6_write_pairs: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_rd && mem_wdata == mem_rdata));

    // R8: the mover only retires while a command is queued
    a_r8_pop_has_entry: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_valid);

endmodule

// File: tb/qdma_engine_tb.sv
module qdma_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BURST_B    = 32;
    localparam int BURST_W    = BURST_B / 4;
    localparam int DEPTH      = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd, mem_wr, irq;
    logic [31:0] mem_raddr, mem_rdata, mem_waddr, mem_wdata;

    logic [31:0] mem [1024];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          mon_on = 1'b0;

    logic [63:0] exp_wr_q [$];
    logic [31:0] exp_rd_q [$];
    int          exp_run_q [$];
    int          run_len = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdma_engine #(.QUEUE_DEPTH(DEPTH), .MAX_BURST_BYTES(BURST_B)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_wr(mem_wr),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .irq(irq)
    );

    assign mem_rdata = mem[mem_raddr[11:2]];
    always @(posedge clk) if (mem_wr) mem[mem_waddr[11:2]] <= mem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compares memory traffic against the scoreboard queues
    always @(negedge clk) begin
        if (mon_on) begin
            if (mem_rd) begin
                run_len++;
                if (exp_rd_q.size() == 0) chk("R5 unexpected read", mem_raddr, 32'hFFFF_FFFF);
                else chk("R5 read address", mem_raddr, exp_rd_q.pop_front());
            end else if (run_len > 0) begin
                if (exp_run_q.size() == 0) chk("R4 unexpected burst", run_len, 0);
                else chk("R4 burst length", run_len, exp_run_q.pop_front());
                run_len = 0;
            end
            if (mem_wr) begin
                if (exp_wr_q.size() == 0) chk("R6 unexpected write", mem_waddr, 32'hFFFF_FFFF);
                else begin
                    logic [63:0] e;
                    e = exp_wr_q.pop_front();
                    chk("R6 write address", mem_waddr, e[63:32]);
                    chk("R6 write data", mem_wdata, e[31:0]);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Driver: computes the expected traffic, then issues the command
    task automatic issue(input logic [31:0] src, input logic [31:0] dst,
                         input int sw, input int dw, input bit lb, input bit accepted);
        if (accepted) begin
            int n;
            n = lb ? ((sw < dw) ? sw : dw) : sw;
            for (int i = 0; i < n; i++) begin
                logic [31:0] sa, da;
                sa = {src[31:2], 2'b00} + 32'(4 * i);
                da = {dst[31:2], 2'b00} + 32'(4 * i);
                exp_rd_q.push_back(sa);
                if (lb) exp_wr_q.push_back({da, mem[sa[11:2]]});
            end
            for (int left = n; left > 0; left -= BURST_W)
                exp_run_q.push_back((left < BURST_W) ? left : BURST_W);
        end
        wr(8'h18, src);
        wr(8'h1C, dst);
        wr(8'h20, 32'(sw));
        wr(8'h24, 32'(dw));
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(8'h14, s);
            if (s[30]) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA5000000 ^ (32'(i) * 32'h0001_0F03);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;

        // Reset state
        rd(8'h0C, v); chk("R11 int status reset", v, 32'h8802_0000);
        rd(8'h10, v); chk("R10 mask reset", v, 32'hFFFF_FFFF);
        rd(8'h14, v); chk("R9 status reset", v, 32'h4000_0000);
        chk("R10 irq after reset", irq, 1'b0);

        // R3: length register width
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R3 source length masked", v, 32'h07FF_FFFF);
        wr(8'h18, 32'h0000_0103);
        rd(8'h18, v); chk("R1 source address readback", v, 32'h0000_0103);

        // R11: clear the reset-time bits
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, v); chk("R11 w1c clears all", v, 32'h0);

        // Non-loopback, unaligned source, destination length ignored (R2 R4 R5 R7)
        issue(32'h0000_0103, 32'h0000_0800, 20, 5, 1'b0, 1'b1);
        wait_idle();
        rd(8'h0C, v); chk("R7 done flags after non-loopback", v, 32'h0000_3000);
        wr(8'h0C, 32'h0000_1000);
        rd(8'h0C, v); chk("R11 partial w1c", v, 32'h0000_2000);
        wr(8'h0C, 32'h0000_2000);

        // Loopback, equal lengths, unaligned destination (R6 R2)
        wr(8'h80, 32'h0000_0010);
        rd(8'h80, v); chk("R6 loopback bit readback", v, 32'h0000_0010);
        issue(32'h0000_0200, 32'h0000_0802, 10, 10, 1'b1, 1'b1);
        wait_idle();
        chk("R6 destination word stored", mem[32'h808 >> 2], mem[32'h208 >> 2]);

        // Loopback with a short destination (R4 R7)
        wr(8'h0C, 32'hFFFF_FFFF);
        issue(32'h0000_0300, 32'h0000_0A00, 12, 5, 1'b1, 1'b1);
        wait_idle();
        rd(8'h0C, v); chk("R7 retire on short destination", v, 32'h0000_3000);

        // Zero-length command (R7)
        wr(8'h0C, 32'hFFFF_FFFF);
        issue(32'h0000_0000, 32'h0000_0000, 0, 0, 1'b1, 1'b1);
        wait_idle();
        rd(8'h0C, v); chk("R7 zero-length retire", v, 32'h0000_3000);

        // Interrupt masking (R10)
        chk("R10 irq masked", irq, 1'b0);
        wr(8'h10, 32'hFFFF_DFFF);
        chk("R10 irq unmasked", irq, 1'b1);
        wr(8'h0C, 32'h0000_2000);
        chk("R10 irq after w1c", irq, 1'b0);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);

        // Queue fill, FIFO order and overflow (R8 R9)
        wr(8'h80, 32'h0);
        issue(32'h0000_0400, 32'h0000_0C00, 64, 0, 1'b0, 1'b1);
        issue(32'h0000_0500, 32'h0000_0C00, 3, 0, 1'b0, 1'b1);
        issue(32'h0000_0600, 32'h0000_0C00, 3, 0, 1'b0, 1'b1);
        issue(32'h0000_0700, 32'h0000_0C00, 3, 0, 1'b0, 1'b1);
        rd(8'h14, v); chk("R9 queue full flag", v, 32'h8000_0000);
        issue(32'h0000_0780, 32'h0000_0C00, 3, 0, 1'b0, 1'b0);
        rd(8'h0C, v); chk("R8 overflow flag", v[14], 1'b1);
        wait_idle();
        rd(8'h14, v); chk("R9 queue empty after drain", v, 32'h4000_0000);

        // Scoreboard must be drained
        chk("R5 pending reads", exp_rd_q.size(), 0);
        chk("R6 pending writes", exp_wr_q.size(), 0);
        chk("R4 pending bursts", exp_run_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule